// File: doc/BRIEF.md
# Thermal Warning and Shutdown Controller

This block turns the digital outputs of several on-die temperature comparators into power-management requests. Each sensor has two thresholds, warm and hot, and each threshold has a rising level and a lower falling level for hysteresis. Each comparator reaches the block as two separate levels: "above rising" and "below falling". The block also takes a warm-mask bit per sensor, a two-bit global reporting code for masked warm events, a level on-request from the enable or voltage-sense pin logic, and an acknowledge from the rail sequencer.

When an unmasked sensor runs warm, the block asks for an orderly, sequenced power-down. When any sensor runs hot, the block asks for an immediate power-off of all rails at once, whatever the masks are. The block then waits for the die to cool. The falling threshold it watches depends on the masks. If at least one sensor is warm-unmasked, it watches the warm falling level. If all sensors are warm-masked, it watches the hot falling level. After the die has cooled, the block raises a restart permission, gated only by the on-request level, so no new push-button press is needed. It holds that permission until the sequencer acknowledges power-up. Per-sensor warm and hot flags and an interrupt request record what happened.

Top module: `thermal_guard`

## Requirements
- R1: While running, a sensor that is above its warm rising level with its mask bit 0 sets its warm flag and the interrupt request after the next clock edge, and seqDownReq goes to 1 after that same edge.
- R2: A warm-masked sensor above warm rising causes no shutdown request. The reporting code maskEffect controls what it does record: 2'b00 sets neither the flag nor the interrupt; 2'b01 sets the warm flag only; 2'b10 and 2'b11 set both the flag and the interrupt. A flag set this way stays set until the next accepted restart acknowledge.
- R3: A sensor above its hot rising level sets its hot flag and the interrupt request, whatever its mask bit. immOffReq goes to 1 after the next edge. This holds from every state, including the warm-off and cooled states.
- R4: When a hot crossing and an unmasked warm crossing arrive in the same cycle, immOffReq is asserted and seqDownReq is not.
- R5: While any mask bit is 0, an off condition (warm-off or hot-off) ends after the first edge at which every sensor is below its warm falling level. A sensor sitting between the warm falling and warm rising levels keeps the block off.
- R6: While all mask bits are 1, an off condition ends after the first edge at which every sensor is below its hot falling level.
- R7: Once the off condition has ended, seqDownReq and immOffReq are 0. restartOk then equals onReqValid combinationally and stays available until an acknowledge is accepted.
- R8: pwrUpAck while restartOk is 1 returns the block to running after that edge. At the same edge restartOk drops and all flags and the interrupt request clear, except bits that a fault sets at that same edge. pwrUpAck has no effect at other times.
- R9: After reset, all outputs are 0 and the block is running.
- R10: In the cooled state, a new hot crossing returns the block to hot-off, and a new unmasked warm crossing returns it to warm-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warmRise | input | NUM_SENS | Sensor is above its warm rising level |
| warmBelowFall | input | NUM_SENS | Sensor is below its warm falling level |
| hotRise | input | NUM_SENS | Sensor is above its hot rising level |
| hotBelowFall | input | NUM_SENS | Sensor is below its hot falling level |
| warmMask | input | NUM_SENS | Per-sensor warm mask, 1 = masked |
| maskEffect | input | 2 | Reporting code for masked warm events |
| onReqValid | input | 1 | On-request level is valid |
| pwrUpAck | input | 1 | Sequencer acknowledges power-up |
| seqDownReq | output | 1 | Sequenced power-down request |
| immOffReq | output | 1 | Immediate simultaneous power-off request |
| restartOk | output | 1 | Restart permitted |
| warmFlag | output | NUM_SENS | Sticky warm status per sensor |
| hotFlag | output | NUM_SENS | Sticky hot status per sensor |
| intReq | output | 1 | Sticky interrupt request |

## Verification
The assertions assume consistent comparator inputs. For any one threshold of a sensor, "above rising" and "below falling" are never both 1. A sensor above hot rising is also above warm rising. The bench meets this by modelling each sensor as a temperature zone from 0 to 4 and deriving all four comparator bits from that zone. The random walk moves a zone by at most one step per cycle, so the comparator outputs change the way a slowly drifting die temperature would make them change. Directed passes force the corner cases: simultaneous hot and warm crossings, all sensors masked, and an acknowledge arriving in the cooled state.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WARMOFF = 2'd1,
    ST_HOTOFF  = 2'd2,
    ST_COOL    = 2'd3
  } guardState_t;

  typedef struct packed {
    logic clrFlags;
  } ctlStrobe_t;
endpackage

// File: rtl/thermal_guard_dp.sv
module thermal_guard_dp
  import thermal_guard_pkg::*;
#(
  parameter int NUM_SENS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SENS-1:0] warmRise,
  input  logic [NUM_SENS-1:0] warmBelowFall,
  input  logic [NUM_SENS-1:0] hotRise,
  input  logic [NUM_SENS-1:0] hotBelowFall,
  input  logic [NUM_SENS-1:0] warmMask,
  input  logic [1:0]          maskEffect,
  input  ctlStrobe_t          strobe,
  output logic                anyHot,
  output logic                anyWarmTrip,
  output logic                coolNow,
  output logic [NUM_SENS-1:0] warmFlag,
  output logic [NUM_SENS-1:0] hotFlag,
  output logic                intReq
);
  logic                maskedRecord;
  logic                maskedSignal;
  logic [NUM_SENS-1:0] tripVec;
  logic [NUM_SENS-1:0] maskedHit;
  logic                allMasked;

  assign maskedRecord = (maskEffect != 2'b00);
  assign maskedSignal = maskEffect[1];
  assign allMasked    = &warmMask;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SENS; gi++) begin : g_sens
      logic warmSet;
      assign tripVec[gi]   = warmRise[gi] & ~warmMask[gi];
      assign maskedHit[gi] = warmRise[gi] & warmMask[gi];
      assign warmSet       = tripVec[gi] | (maskedHit[gi] & maskedRecord);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          warmFlag[gi] <= 1'b0;
          hotFlag[gi]  <= 1'b0;
        end else begin
          warmFlag[gi] <= (warmFlag[gi] & ~strobe.clrFlags) | warmSet;
          hotFlag[gi]  <= (hotFlag[gi] & ~strobe.clrFlags) | hotRise[gi];
        end
      end

      // R3: hot flag cannot be masked
      a_r3_hot_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hotRise[gi] |=> hotFlag[gi]);
      // R2: masked warm with code 00 leaves no record
      a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (maskedHit[gi] && maskEffect == 2'b00) |=> (!warmFlag[gi] || $past(warmFlag[gi])));
    end
  endgenerate

  assign anyHot      = |hotRise;
  assign anyWarmTrip = |tripVec;
  assign coolNow     = allMasked ? (&hotBelowFall) : (&warmBelowFall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intReq <= 1'b0;
    end else begin
      intReq <= (intReq & ~strobe.clrFlags) | anyHot | anyWarmTrip
                | ((|maskedHit) & maskedSignal);
    end
  end

  // R2: masked warm with code 01 records but does not interrupt
  a_r2_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyHot && !anyWarmTrip && maskEffect == 2'b01 && !intReq) |=> !intReq);
endmodule

// File: rtl/thermal_guard_ctrl.sv
module thermal_guard_ctrl
  import thermal_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyHot,
  input  logic       anyWarmTrip,
  input  logic       coolNow,
  input  logic       onReqValid,
  input  logic       pwrUpAck,
  output ctlStrobe_t strobe,
  output logic       seqDownReq,
  output logic       immOffReq,
  output logic       restartOk
);
  guardState_t stateQ, stateD;
  logic        ackTaken;

  assign restartOk = (stateQ == ST_COOL) && onReqValid;
  assign ackTaken  = restartOk && pwrUpAck && !anyHot && !anyWarmTrip;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN: begin
        if (anyHot)           stateD = ST_HOTOFF;
        else if (anyWarmTrip) stateD = ST_WARMOFF;
      end
      ST_WARMOFF: begin
        if (anyHot)       stateD = ST_HOTOFF;
        else if (coolNow) stateD = ST_COOL;
      end
      ST_HOTOFF: begin
        if (!anyHot && coolNow) stateD = ST_COOL;
      end
      ST_COOL: begin
        if (anyHot)           stateD = ST_HOTOFF;
        else if (anyWarmTrip) stateD = ST_WARMOFF;
        else if (ackTaken)    stateD = ST_RUN;
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_RUN;
    else        stateQ <= stateD;
  end

  always_comb begin
    strobe          = '0;
    strobe.clrFlags = ackTaken;
  end

  assign seqDownReq = (stateQ == ST_WARMOFF);
  assign immOffReq  = (stateQ == ST_HOTOFF);

  // R3: any hot crossing forces the simultaneous power-off
  a_r3_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
    anyHot |=> immOffReq);
  // R4: hot wins over warm in the same cycle
  a_r4_hot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (anyHot && anyWarmTrip) |=> !seqDownReq);
  // R1: unmasked warm crossing requests sequenced power-down
  a_r1_warm_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (anyWarmTrip && !anyHot && !immOffReq) |=> seqDownReq);
  // R8: accepted acknowledge returns to running
  a_r8_ack_run: assert property (@(posedge clk) disable iff (!rst_n)
    (restartOk && pwrUpAck && !anyHot && !anyWarmTrip) |=> (!restartOk && !seqDownReq && !immOffReq));
  // R7: cooled state is held without acknowledge or new fault
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_COOL && !pwrUpAck && !anyHot && !anyWarmTrip) |=> (stateQ == ST_COOL));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int NUM_SENS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SENS-1:0] warmRise,
  input  logic [NUM_SENS-1:0] warmBelowFall,
  input  logic [NUM_SENS-1:0] hotRise,
  input  logic [NUM_SENS-1:0] hotBelowFall,
  input  logic [NUM_SENS-1:0] warmMask,
  input  logic [1:0]          maskEffect,
  input  logic                onReqValid,
  input  logic                pwrUpAck,
  output logic                seqDownReq,
  output logic                immOffReq,
  output logic                restartOk,
  output logic [NUM_SENS-1:0] warmFlag,
  output logic [NUM_SENS-1:0] hotFlag,
  output logic                intReq
);
  ctlStrobe_t strobe;
  logic       anyHot;
  logic       anyWarmTrip;
  logic       coolNow;

  thermal_guard_dp #(.NUM_SENS(NUM_SENS)) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .warmRise     (warmRise),
    .warmBelowFall(warmBelowFall),
    .hotRise      (hotRise),
    .hotBelowFall (hotBelowFall),
    .warmMask     (warmMask),
    .maskEffect   (maskEffect),
    .strobe       (strobe),
    .anyHot       (anyHot),
    .anyWarmTrip  (anyWarmTrip),
    .coolNow      (coolNow),
    .warmFlag     (warmFlag),
    .hotFlag      (hotFlag),
    .intReq       (intReq)
  );

  thermal_guard_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .anyHot     (anyHot),
    .anyWarmTrip(anyWarmTrip),
    .coolNow    (coolNow),
    .onReqValid (onReqValid),
    .pwrUpAck   (pwrUpAck),
    .strobe     (strobe),
    .seqDownReq (seqDownReq),
    .immOffReq  (immOffReq),
    .restartOk  (restartOk)
  );
endmodule

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb_top;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] warmRise, warmBelowFall, hotRise, hotBelowFall, warmMask;
  logic [1:0]   maskEffect;
  logic         onReqValid, pwrUpAck;
  logic         seqDownReq, immOffReq, restartOk, intReq;
  logic [N-1:0] warmFlag, hotFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int zone [N];

  // bench reference state: 0 run, 1 warm-off, 2 hot-off, 3 cooled
  int           mSt;
  logic [N-1:0] mWarmF, mHotF;
  logic         mInt;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_guard #(.NUM_SENS(N)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .warmRise(warmRise), .warmBelowFall(warmBelowFall),
    .hotRise(hotRise), .hotBelowFall(hotBelowFall),
    .warmMask(warmMask), .maskEffect(maskEffect),
    .onReqValid(onReqValid), .pwrUpAck(pwrUpAck),
    .seqDownReq(seqDownReq), .immOffReq(immOffReq), .restartOk(restartOk),
    .warmFlag(warmFlag), .hotFlag(hotFlag), .intReq(intReq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // zone: 0 below warm fall, 1 warm hysteresis, 2 warm, 3 hot hysteresis, 4 hot
  task automatic applyZones();
    for (int i = 0; i < N; i++) begin
      warmBelowFall[i] = (zone[i] == 0);
      warmRise[i]      = (zone[i] >= 2);
      hotBelowFall[i]  = (zone[i] <= 2);
      hotRise[i]       = (zone[i] == 4);
    end
  endtask

  task automatic setAll(input int z);
    for (int i = 0; i < N; i++) zone[i] = z;
    applyZones();
  endtask

  function automatic logic expRestart();
    return (mSt == 3) && onReqValid;
  endfunction

  task automatic modelStep();
    logic anyHot, trip, cool, clr;
    logic [N-1:0] wset, mhit;
    anyHot = |hotRise;
    trip   = |(warmRise & ~warmMask);
    mhit   = warmRise & warmMask;
    cool   = (&warmMask) ? (&hotBelowFall) : (&warmBelowFall);
    wset   = (warmRise & ~warmMask) | (mhit & {N{maskEffect != 2'b00}});
    clr    = (mSt == 3) && onReqValid && pwrUpAck && !anyHot && !trip;
    mWarmF = (mWarmF & ~{N{clr}}) | wset;
    mHotF  = (mHotF & ~{N{clr}}) | hotRise;
    mInt   = (mInt & ~clr) | anyHot | trip | ((|mhit) & maskEffect[1]);
    case (mSt)
      0: if (anyHot) mSt = 2; else if (trip) mSt = 1;
      1: if (anyHot) mSt = 2; else if (cool) mSt = 3;
      2: if (!anyHot && cool) mSt = 3;
      default: if (anyHot) mSt = 2; else if (trip) mSt = 1; else if (clr) mSt = 0;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "seqDownReq", 32'(seqDownReq), 32'(mSt == 1));
    chk(tag, "immOffReq",  32'(immOffReq),  32'(mSt == 2));
    chk(tag, "restartOk",  32'(restartOk),  32'(expRestart()));
    chk(tag, "warmFlag",   32'(warmFlag),   32'(mWarmF));
    chk(tag, "hotFlag",    32'(hotFlag),    32'(mHotF));
    chk(tag, "intReq",     32'(intReq),     32'(mInt));
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    #1;
    modelStep();
    compareAll(tag);
  endtask

  initial begin
    setAll(0);
    warmMask = '0; maskEffect = 2'b00; onReqValid = 1'b0; pwrUpAck = 1'b0;
    mSt = 0; mWarmF = '0; mHotF = '0; mInt = 1'b0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    compareAll("R9");
    chk("R9", "all outputs", 32'({seqDownReq, immOffReq, restartOk, warmFlag, hotFlag, intReq}), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    tick("R9");

    // R1: unmasked warm crossing on sensor 1
    zone[1] = 2; applyZones();
    tick("R1");
    chk("R1", "seqDownReq", 32'(seqDownReq), 32'd1);
    chk("R1", "warmFlag", 32'(warmFlag), 32'b0010);
    // R5: one sensor in hysteresis keeps off
    setAll(0); zone[1] = 1; applyZones();
    tick("R5");
    chk("R5", "seqDownReq held", 32'(seqDownReq), 32'd1);
    setAll(0);
    tick("R5");
    chk("R5", "seqDownReq released", 32'(seqDownReq), 32'd0);
    // R7: restart follows the on-request level, held without ack
    onReqValid = 1'b0; #1;
    chk("R7", "restartOk no request", 32'(restartOk), 32'd0);
    onReqValid = 1'b1; #1;
    chk("R7", "restartOk request", 32'(restartOk), 32'd1);
    repeat (3) tick("R7");
    // R8: ack clears flags and returns to run
    pwrUpAck = 1'b1;
    tick("R8");
    pwrUpAck = 1'b0;
    chk("R8", "warmFlag cleared", 32'(warmFlag), 32'd0);
    chk("R8", "restartOk dropped", 32'(restartOk), 32'd0);
    tick("R8");

    // R2: masked warm with each reporting code
    warmMask = 4'b0100; zone[2] = 2; applyZones();
    maskEffect = 2'b00; tick("R2");
    chk("R2", "code00 flag", 32'(warmFlag), 32'd0);
    maskEffect = 2'b01; tick("R2");
    chk("R2", "code01 int", 32'(intReq), 32'd0);
    maskEffect = 2'b10; tick("R2");
    chk("R2", "code10 int", 32'(intReq), 32'd1);
    chk("R2", "no shutdown", 32'(seqDownReq), 32'd0);

    // R4: hot and unmasked warm together, hot on masked sensor (R3)
    zone[2] = 4; zone[0] = 2; applyZones();
    tick("R4");
    chk("R4", "immOffReq", 32'(immOffReq), 32'd1);
    chk("R4", "seqDownReq", 32'(seqDownReq), 32'd0);
    chk("R3", "hotFlag masked sensor", 32'(hotFlag), 32'b0100);
    // R5: unmasked sensors exist, hot hysteresis not enough
    setAll(1);
    tick("R5");
    chk("R5", "still hot-off", 32'(immOffReq), 32'd1);
    // R6: all masked, below hot falling is enough
    warmMask = '1;
    tick("R6");
    chk("R6", "cooled", 32'(immOffReq), 32'd0);
    chk("R6", "restartOk", 32'(restartOk), 32'd1);
    // R10: new hot crossing in cooled state
    zone[3] = 4; applyZones();
    tick("R10");
    chk("R10", "back to hot-off", 32'(immOffReq), 32'd1);
    setAll(2);
    tick("R6");
    warmMask = 4'b0001;
    tick("R10");
    setAll(0); warmMask = '0;
    tick("R10");
    zone[0] = 2; applyZones();
    tick("R10");
    chk("R10", "back to warm-off", 32'(seqDownReq), 32'd1);
    setAll(0);
    pwrUpAck = 1'b1; tick("R8"); tick("R8"); pwrUpAck = 1'b0;

    // random walk
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom_range(0, 15));
        if (r == 0 && zone[i] < 4) zone[i]++;
        else if (r <= 2 && zone[i] > 0) zone[i]--;
      end
      applyZones();
      if ($urandom_range(0, 63) == 0) warmMask = N'($urandom);
      if ($urandom_range(0, 31) == 0) maskEffect = 2'($urandom);
      onReqValid = ($urandom_range(0, 3) != 0);
      pwrUpAck = ($urandom_range(0, 3) == 0);
      tick("R1 R2 R3 R5 R6 R7 R8 R10 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule